// File: doc/BRIEF.md
# Two-Level Coarse Page-Table Walker

This block turns a 32-bit virtual address into a physical address by reading a two-level translation table in memory. The address space is flat: the input address goes straight into the walk with no segment stage in front of it. Pages are 4 KB. A first-level table aligned to 16 KB points to coarse second-level tables aligned to 1 KB, and each table entry is one 32-bit word.

A requester sets up the table base word and the virtual address and pulses `start`. The walker then makes at most two reads through a single-request memory port. That port holds its request until the memory answers with a valid response. After each read the walker checks the fixed type code of the entry. When both entries are well formed, it returns the physical address, the 4-bit domain number and the two cacheability bits. When an entry is malformed, it stops and reports a translation fault that says which level failed. Only one walk is in flight at a time. Domain access rights are not checked here.

Top module: `pgwalk_coarse`

## Requirements
- R1: After reset, `done`, `busy`, `fault`, `fault_lvl`, `mem_req`, `cache_wb`, `cache_wt`, `domain` and `pa` are all zero.
- R2: The first read is issued on the cycle after `start` is accepted. Its word address is `{ttbr[31:14], vaddr[31:20], 2'b00}`. Bits 13:0 of `ttbr` are ignored, and `vaddr` and `ttbr` may change after the accepting edge without effect.
- R3: A first-level entry is accepted only if bits 1:0 equal `01`, bit 4 is 1 and bit 9 is 0. Any other entry ends the walk after that single read, with `fault`=1 and `fault_lvl`=0.
- R4: After an accepted first-level entry E1, the second read is issued on the next cycle. Its address is `{E1[31:10], vaddr[19:12], 2'b00}`.
- R5: A second-level entry is accepted only if bits 1:0 equal `11`, bits 4:2 equal `100` and bits 11:9 equal `000`. Any other entry ends the walk with `fault`=1 and `fault_lvl`=1.
- R6: On success, `pa` = `{E2[31:12], vaddr[11:0]}`, where E2 is the second-level entry.
- R7: On success, `domain` = E1[8:5], `cache_wb` = E1[2] and `cache_wt` = E1[3], and `fault` = 0.
- R8: While `mem_req` is high and `mem_rvalid` is low, `mem_req` stays high and `mem_addr` stays stable. Any number of wait cycles is tolerated.
- R9: `done` is a one-cycle pulse on the cycle after the final read response. On a fault, `pa`, `domain`, `cache_wb` and `cache_wt` are zero. The result outputs hold their values until the next walk completes.
- R10: `start` is ignored while `busy` is high, and the walk in progress finishes with the operands it latched at the start.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | Clock |
| rst_n | input | 1 | Active-low asynchronous reset |
| start | input | 1 | Begin a walk (taken only when idle) |
| vaddr | input | 32 | Virtual address to translate |
| ttbr | input | 32 | Translation table base word (bits 31:14 used) |
| busy | output | 1 | A walk is in progress |
| done | output | 1 | One-cycle completion pulse |
| fault | output | 1 | Walk ended on a malformed entry |
| fault_lvl | output | 1 | 0 = first level failed, 1 = second level failed |
| pa | output | 32 | Physical address |
| domain | output | 4 | Domain number from the first-level entry |
| cache_wb | output | 1 | Write-back cacheable bit |
| cache_wt | output | 1 | Write-through cacheable bit |
| mem_req | output | 1 | Memory read request, held until answered |
| mem_addr | output | 32 | Word address of the requested entry |
| mem_rvalid | input | 1 | Read data valid |
| mem_rdata | input | 32 | Read data |

## Verification
The bench aims at the fixed-bit checks one bit at a time: a wrong type code, a cleared must-be-one bit, and a set must-be-zero bit, at each level. A walker that checks only the type field would return a translation for these entries instead of a fault. A first-level fault must end the walk without a second read; a design that skipped that exit would issue a stray second request. The bench also uses all-ones indices and a table base word with its low bits set, so a shift or mask error in the index arithmetic shows up as a wrong address. It pulses `start` in the middle of a walk and changes the inputs after the accepting edge, which catches a design that re-latches its operands.

// File: rtl/pgwalk_pkg.sv
package pgwalk_pkg;
  localparam int VA_W     = 32;
  localparam int L1_IDX_W = 12;
  localparam int L2_IDX_W = 8;
  localparam int OFF_W    = 12;
  localparam int ENT_SH   = 2;
  localparam int TTB_LSB  = L1_IDX_W + ENT_SH;   // 16 KB aligned first table
  localparam int L2B_LSB  = L2_IDX_W + ENT_SH;   // 1 KB aligned coarse table
  localparam int DOM_W    = 4;
  localparam int DOM_LSB  = 5;

  typedef enum logic [1:0] {ST_IDLE, ST_L1, ST_L2, ST_FIN} walk_st_e;

  typedef struct packed {
    logic [VA_W-1:0]  pa;
    logic [DOM_W-1:0] dom;
    logic             wb;
    logic             wt;
    logic             fault;
    logic             lvl;
  } walk_res_t;

  function automatic logic [VA_W-1:0] l1_entry_addr(input logic [VA_W-1:0] ttb,
                                                    input logic [VA_W-1:0] va);
    return {ttb[VA_W-1:TTB_LSB], va[VA_W-1:VA_W-L1_IDX_W], {ENT_SH{1'b0}}};
  endfunction

  function automatic logic [VA_W-1:0] l2_entry_addr(input logic [VA_W-1:0] e1,
                                                    input logic [VA_W-1:0] va);
    return {e1[VA_W-1:L2B_LSB], va[OFF_W+L2_IDX_W-1:OFF_W], {ENT_SH{1'b0}}};
  endfunction

  function automatic logic [VA_W-1:0] phys_addr(input logic [VA_W-1:0] e2,
                                                input logic [VA_W-1:0] va);
    return {e2[VA_W-1:OFF_W], va[OFF_W-1:0]};
  endfunction

  function automatic walk_res_t fault_res(input logic lvl);
    walk_res_t r;
    r       = '0;
    r.fault = 1'b1;
    r.lvl   = lvl;
    return r;
  endfunction
endpackage

// File: rtl/pgwalk_desc_chk.sv
module pgwalk_desc_chk #(
  parameter bit SECOND = 1'b0,
  parameter bit STRICT = 1'b1
) (
  input  logic [31:0] desc,
  output logic        ok
);
  logic type_ok;
  logic fixed_ok;

  generate
    if (SECOND) begin : g_l2
      assign type_ok = (desc[1:0] == 2'b11);
      if (STRICT) begin : g_strict
        assign fixed_ok = (desc[4:2] == 3'b100) && (desc[11:9] == 3'b000);
      end else begin : g_loose
        assign fixed_ok = 1'b1;
      end
    end else begin : g_l1
      assign type_ok = (desc[1:0] == 2'b01);
      if (STRICT) begin : g_strict
        assign fixed_ok = desc[4] && !desc[9];
      end else begin : g_loose
        assign fixed_ok = 1'b1;
      end
    end
  endgenerate

  assign ok = type_ok && fixed_ok;
endmodule

// File: rtl/pgwalk_addr_gen.sv
module pgwalk_addr_gen
  import pgwalk_pkg::*;
(
  input  logic            sel_l2,
  input  logic [VA_W-1:0] ttb,
  input  logic [VA_W-1:0] va,
  input  logic [VA_W-1:0] e1,
  output logic [VA_W-1:0] addr
);
  logic [VA_W-1:0] a1;
  logic [VA_W-1:0] a2;

  assign a1   = l1_entry_addr(ttb, va);
  assign a2   = l2_entry_addr(e1, va);
  assign addr = sel_l2 ? a2 : a1;
endmodule

// File: rtl/pgwalk_ctrl.sv
module pgwalk_ctrl
  import pgwalk_pkg::*;
(
  input  logic     clk,
  input  logic     rst_n,
  input  logic     start,
  input  logic     mem_rvalid,
  input  logic     l1_ok,
  input  logic     l2_ok,
  output walk_st_e state,
  output logic     evt_accept,
  output logic     evt_l1_take,
  output logic     evt_l2_take,
  output logic     evt_l1_bad,
  output logic     evt_l2_bad
);
  walk_st_e nxt;

  assign evt_accept  = (state == ST_IDLE) && start;
  assign evt_l1_take = (state == ST_L1) && mem_rvalid;
  assign evt_l2_take = (state == ST_L2) && mem_rvalid;
  assign evt_l1_bad  = evt_l1_take && !l1_ok;
  assign evt_l2_bad  = evt_l2_take && !l2_ok;

  always_comb begin
    nxt = state;
    unique case (state)
      ST_IDLE: if (start) nxt = ST_L1;
      ST_L1:   if (mem_rvalid) nxt = l1_ok ? ST_L2 : ST_FIN;
      ST_L2:   if (mem_rvalid) nxt = ST_FIN;
      ST_FIN:  nxt = ST_IDLE;
      default: nxt = ST_IDLE;
    endcase
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) state <= ST_IDLE;
    else        state <= nxt;
  end
endmodule

// File: rtl/pgwalk_coarse.sv
module pgwalk_coarse
  import pgwalk_pkg::*;
#(
  parameter bit STRICT_FIXED = 1'b1
) (
  input  logic        clk,
  input  logic        rst_n,
  input  logic        start,
  input  logic [31:0] vaddr,
  input  logic [31:0] ttbr,
  output logic        busy,
  output logic        done,
  output logic        fault,
  output logic        fault_lvl,
  output logic [31:0] pa,
  output logic [3:0]  domain,
  output logic        cache_wb,
  output logic        cache_wt,
  output logic        mem_req,
  output logic [31:0] mem_addr,
  input  logic        mem_rvalid,
  input  logic [31:0] mem_rdata
);
  walk_st_e        state;
  logic            evt_accept, evt_l1_take, evt_l2_take, evt_l1_bad, evt_l2_bad;
  logic            l1_ok, l2_ok;
  logic [VA_W-1:0] va_q, ttb_q, e1_q;
  walk_res_t       res_q;

  pgwalk_desc_chk #(.SECOND(1'b0), .STRICT(STRICT_FIXED)) u_chk_l1 (
    .desc(mem_rdata), .ok(l1_ok));
  pgwalk_desc_chk #(.SECOND(1'b1), .STRICT(STRICT_FIXED)) u_chk_l2 (
    .desc(mem_rdata), .ok(l2_ok));

  pgwalk_ctrl u_ctrl (
    .clk(clk), .rst_n(rst_n), .start(start), .mem_rvalid(mem_rvalid),
    .l1_ok(l1_ok), .l2_ok(l2_ok), .state(state),
    .evt_accept(evt_accept), .evt_l1_take(evt_l1_take), .evt_l2_take(evt_l2_take),
    .evt_l1_bad(evt_l1_bad), .evt_l2_bad(evt_l2_bad));

  pgwalk_addr_gen u_addr (
    .sel_l2(state == ST_L2), .ttb(ttb_q), .va(va_q), .e1(e1_q), .addr(mem_addr));

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      va_q  <= '0;
      ttb_q <= '0;
      e1_q  <= '0;
    end else begin
      if (evt_accept) begin
        va_q  <= vaddr;
        ttb_q <= ttbr;
      end
      if (evt_l1_take) e1_q <= mem_rdata;
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      res_q <= '0;
    end else if (evt_l1_bad) begin
      res_q <= fault_res(1'b0);
    end else if (evt_l2_bad) begin
      res_q <= fault_res(1'b1);
    end else if (evt_l2_take) begin
      res_q.pa    <= phys_addr(mem_rdata, va_q);
      res_q.dom   <= e1_q[DOM_LSB+DOM_W-1:DOM_LSB];
      res_q.wb    <= e1_q[2];
      res_q.wt    <= e1_q[3];
      res_q.fault <= 1'b0;
      res_q.lvl   <= 1'b0;
    end
  end

  assign mem_req   = (state == ST_L1) || (state == ST_L2);
  assign busy      = mem_req;
  assign done      = (state == ST_FIN);
  assign fault     = res_q.fault;
  assign fault_lvl = res_q.lvl;
  assign pa        = res_q.pa;
  assign domain    = res_q.dom;
  assign cache_wb  = res_q.wb;
  assign cache_wt  = res_q.wt;
endmodule

// File: rtl/pgwalk_coarse_chk.sv
module pgwalk_coarse_chk (
  input logic        clk,
  input logic        rst_n,
  input logic        busy,
  input logic        done,
  input logic        fault,
  input logic        fault_lvl,
  input logic [31:0] pa,
  input logic [3:0]  domain,
  input logic        cache_wb,
  input logic        cache_wt,
  input logic        mem_req,
  input logic [31:0] mem_addr,
  input logic        mem_rvalid,
  input logic        evt_accept,
  input logic        evt_l1_take,
  input logic        evt_l1_bad,
  input logic        evt_l2_bad,
  input logic [31:0] va_q
);
  p_req_hold_r8: assert property (@(posedge clk) disable iff (!rst_n)
    (mem_req && !mem_rvalid) |=> (mem_req && $stable(mem_addr)));

  p_done_pulse_r9: assert property (@(posedge clk) disable iff (!rst_n)
    done |=> !done);

  p_fault_zero_r9: assert property (@(posedge clk) disable iff (!rst_n)
    (done && fault) |-> (pa == 32'd0 && domain == 4'd0 && !cache_wb && !cache_wt));

  p_l1_fault_r3: assert property (@(posedge clk) disable iff (!rst_n)
    evt_l1_bad |=> (done && fault && !fault_lvl && !mem_req));

  p_l2_fault_r5: assert property (@(posedge clk) disable iff (!rst_n)
    evt_l2_bad |=> (done && fault && fault_lvl));

  p_l2_index_r4: assert property (@(posedge clk) disable iff (!rst_n)
    (evt_l1_take && !evt_l1_bad) |=>
      (mem_req && mem_addr[1:0] == 2'b00 && mem_addr[9:2] == va_q[19:12]));

  p_busy_no_accept_r10: assert property (@(posedge clk) disable iff (!rst_n)
    busy |-> !evt_accept);
endmodule

bind pgwalk_coarse pgwalk_coarse_chk u_chk (
  .clk(clk), .rst_n(rst_n), .busy(busy), .done(done), .fault(fault),
  .fault_lvl(fault_lvl), .pa(pa), .domain(domain), .cache_wb(cache_wb),
  .cache_wt(cache_wt), .mem_req(mem_req), .mem_addr(mem_addr),
  .mem_rvalid(mem_rvalid), .evt_accept(evt_accept), .evt_l1_take(evt_l1_take),
  .evt_l1_bad(evt_l1_bad), .evt_l2_bad(evt_l2_bad), .va_q(va_q));

// File: tb/pgwalk_coarse_tb_top.sv
module pgwalk_coarse_tb_top;
  localparam int CLK_PERIOD = 10;
  localparam int WATCHDOG   = 20000;

  logic        clk = 1'b0;
  logic        rst_n = 1'b0;
  logic        start = 1'b0;
  logic [31:0] vaddr = '0;
  logic [31:0] ttbr = '0;
  logic        busy, done, fault, fault_lvl, cache_wb, cache_wt, mem_req;
  logic [31:0] pa, mem_addr;
  logic [3:0]  domain;
  logic        mem_rvalid = 1'b0;
  logic [31:0] mem_rdata = '0;

  int n_chk = 0;
  int n_fail = 0;
  bit finished = 1'b0;

  always #(CLK_PERIOD/2) clk = ~clk;

  pgwalk_coarse dut_i (
    .clk(clk), .rst_n(rst_n), .start(start), .vaddr(vaddr), .ttbr(ttbr),
    .busy(busy), .done(done), .fault(fault), .fault_lvl(fault_lvl), .pa(pa),
    .domain(domain), .cache_wb(cache_wb), .cache_wt(cache_wt),
    .mem_req(mem_req), .mem_addr(mem_addr), .mem_rvalid(mem_rvalid),
    .mem_rdata(mem_rdata));

  task automatic chk(input bit ok, input string tag, input logic [31:0] act,
                     input logic [31:0] exp);
    n_chk++;
    if (!ok) begin
      n_fail++;
      $display("FAIL %s actual=%h expected=%h at %0t", tag, act, exp, $time);
    end
  endtask

  // Reference model: arithmetic restated with masks and shifts.
  function automatic logic [31:0] ref_l1_addr(input logic [31:0] t, input logic [31:0] v);
    return (t & 32'hFFFF_C000) + ((v >> 20) * 4);
  endfunction
  function automatic logic [31:0] ref_l2_addr(input logic [31:0] e, input logic [31:0] v);
    return (e & 32'hFFFF_FC00) + (((v >> 12) % 256) * 4);
  endfunction
  function automatic bit ref_l1_ok(input logic [31:0] e);
    return (e % 4 == 1) && ((e >> 4) % 2 == 1) && ((e >> 9) % 2 == 0);
  endfunction
  function automatic bit ref_l2_ok(input logic [31:0] e);
    return (e % 4 == 3) && ((e >> 2) % 8 == 4) && ((e >> 9) % 8 == 0);
  endfunction
  function automatic logic [31:0] mk_l1(input logic [31:0] base, input int dom,
                                        input bit wb, input bit wt);
    return (base << 10) | (dom << 5) | 32'h10 | (wt << 3) | (wb << 2) | 32'h1;
  endfunction
  function automatic logic [31:0] mk_l2(input logic [31:0] base);
    return (base << 12) | 32'h13;
  endfunction

  task automatic walk(input logic [31:0] va, input logic [31:0] tb,
                      input logic [31:0] e1, input logic [31:0] e2,
                      input int lat1, input int lat2, input bit poke, input string nm);
    logic [31:0] a1, a2, exp_pa;
    bit ok1, ok2;
    a1  = ref_l1_addr(tb, va);
    ok1 = ref_l1_ok(e1);
    a2  = ref_l2_addr(e1, va);
    ok2 = ref_l2_ok(e2);
    exp_pa = (e2 & 32'hFFFF_F000) | (va & 32'h0000_0FFF);
    start = 1'b1; vaddr = va; ttbr = tb;
    @(negedge clk);
    start = 1'b0; vaddr = 32'hDEAD_BEEF; ttbr = 32'h5555_5555;
    chk(mem_req && busy, {nm, " R2 first read issued"}, {31'd0, mem_req}, 32'd1);
    chk(mem_addr == a1, {nm, " R2 first address"}, mem_addr, a1);
    for (int i = 0; i < lat1; i++) begin
      if (poke && i == 0) begin start = 1'b1; vaddr = ~va; ttbr = ~tb; end
      @(negedge clk);
      start = 1'b0;
      chk(mem_req && mem_addr == a1 && !done, {nm, " R8 R10 hold first read"}, mem_addr, a1);
    end
    mem_rvalid = 1'b1; mem_rdata = e1;
    @(negedge clk);
    mem_rvalid = 1'b0; mem_rdata = 32'h0;
    if (!ok1) begin
      chk(done && fault && !fault_lvl, {nm, " R3 first-level fault"},
          {29'd0, done, fault, fault_lvl}, 32'd6);
      chk(!mem_req, {nm, " R3 no second read"}, {31'd0, mem_req}, 32'd0);
      chk(pa == 0 && domain == 0 && !cache_wb && !cache_wt, {nm, " R9 fault zeros"}, pa, 32'd0);
    end else begin
      chk(mem_req && mem_addr == a2, {nm, " R4 second address"}, mem_addr, a2);
      for (int i = 0; i < lat2; i++) begin
        @(negedge clk);
        chk(mem_req && mem_addr == a2 && !done, {nm, " R8 hold second read"}, mem_addr, a2);
      end
      mem_rvalid = 1'b1; mem_rdata = e2;
      @(negedge clk);
      mem_rvalid = 1'b0; mem_rdata = 32'h0;
      chk(done, {nm, " R9 done pulse"}, {31'd0, done}, 32'd1);
      if (!ok2) begin
        chk(fault && fault_lvl, {nm, " R5 second-level fault"}, {30'd0, fault, fault_lvl}, 32'd3);
        chk(pa == 0 && domain == 0 && !cache_wb && !cache_wt, {nm, " R9 fault zeros"}, pa, 32'd0);
      end else begin
        chk(!fault, {nm, " R7 no fault"}, {31'd0, fault}, 32'd0);
        chk(pa == exp_pa, {nm, " R6 physical address"}, pa, exp_pa);
        chk(domain == 4'((e1 >> 5) % 16), {nm, " R7 domain"}, {28'd0, domain}, (e1 >> 5) % 16);
        chk(cache_wb == e1[2] && cache_wt == e1[3], {nm, " R7 cache bits"},
            {30'd0, cache_wb, cache_wt}, {30'd0, e1[2], e1[3]});
      end
    end
    @(negedge clk);
    chk(!done && !busy, {nm, " R9 done one cycle"}, {30'd0, done, busy}, 32'd0);
    chk(pa == (ok1 && ok2 ? exp_pa : 32'd0), {nm, " R9 result held"}, pa,
        ok1 && ok2 ? exp_pa : 32'd0);
  endtask

  initial begin : wd
    repeat (WATCHDOG) @(posedge clk);
    if (!finished) begin
      n_chk++;
      n_fail++;
      $display("FAIL watchdog expired actual=%0d expected=0", WATCHDOG);
      $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
      $finish;
    end
  end

  initial begin : main
    repeat (3) @(negedge clk);
    chk(!done && !busy && !fault && !fault_lvl && !mem_req && pa == 0 && domain == 0
        && !cache_wb && !cache_wt, "R1 reset state", pa, 32'd0);
    rst_n = 1'b1;
    @(negedge clk);
    chk(!mem_req && !busy, "R1 idle after reset", {31'd0, mem_req}, 32'd0);

    walk(32'h1234_5678, 32'h8000_7ABC, mk_l1(32'h2A_5A5A, 9, 1'b1, 1'b0),
         mk_l2(32'hC_AFE0), 0, 0, 1'b0, "basic");
    walk(32'h0040_1ABC, 32'h0001_C000, mk_l1(32'h00_1234, 3, 1'b0, 1'b1),
         mk_l2(32'h7_7777), 3, 5, 1'b1, "latency+poke");
    walk(32'hFFFF_FFFF, 32'hFFFF_FFFF, mk_l1(32'h3F_FFFF, 15, 1'b1, 1'b1),
         mk_l2(32'hF_FFFF), 1, 2, 1'b0, "all-ones");
    walk(32'h0000_0000, 32'h0000_4000, mk_l1(32'h00_0001, 0, 1'b0, 1'b0),
         mk_l2(32'h0_0001), 0, 1, 1'b0, "zeros");
    walk(32'h1234_5678, 32'h8000_0000, mk_l1(32'h2A_5A5A, 9, 1'b1, 1'b0) & ~32'h3,
         mk_l2(32'h1), 2, 0, 1'b0, "R3 type00");
    walk(32'h1234_5678, 32'h8000_0000, (mk_l1(32'h11, 2, 1'b0, 1'b0) & ~32'h3) | 32'h2,
         mk_l2(32'h1), 0, 0, 1'b0, "R3 type10");
    walk(32'h1234_5678, 32'h8000_0000, mk_l1(32'h11, 2, 1'b0, 1'b0) & ~32'h10,
         mk_l2(32'h1), 0, 0, 1'b0, "R3 bit4 clear");
    walk(32'h1234_5678, 32'h8000_0000, mk_l1(32'h11, 2, 1'b0, 1'b0) | 32'h200,
         mk_l2(32'h1), 0, 0, 1'b0, "R3 bit9 set");
    walk(32'hABCD_E123, 32'h4000_0000, mk_l1(32'h22, 5, 1'b1, 1'b0),
         mk_l2(32'h5_4321) & ~32'h2, 0, 3, 1'b0, "R5 type01");
    walk(32'hABCD_E123, 32'h4000_0000, mk_l1(32'h22, 5, 1'b1, 1'b0),
         mk_l2(32'h5_4321) ^ 32'h18, 0, 0, 1'b0, "R5 bits4-2");
    walk(32'hABCD_E123, 32'h4000_0000, mk_l1(32'h22, 5, 1'b1, 1'b0),
         mk_l2(32'h5_4321) | 32'h400, 0, 0, 1'b0, "R5 bit10 set");
    walk(32'h8765_4321, 32'h1234_C000, mk_l1(32'h15_0F0F, 12, 1'b0, 1'b1),
         mk_l2(32'hA_BCDE), 4, 4, 1'b0, "after faults");

    finished = 1'b1;
    $display("End of test - %0d assertions evaluated, %0d failures", n_chk, n_fail);
    $finish;
  end
endmodule